// File: doc/BRIEF.md
# Interrupt Request and Acknowledge Sequencer

This block sits between a core and its external interrupt and reset pins. It brings three asynchronous inputs into the clock domain: a level-sensitive maskable request, an edge-sensitive non-maskable request and a warm reset request. For each of them it then applies the timing rule that makes the input count.

A warm reset is recognised only after the synchronised request has been high for a minimum number of clocks. A non-maskable edge counts only if the line was low for a minimum number of clocks before it. An accepted edge is held pending and handed to the core as a one-clock event. A maskable request is taken only while the core's interrupt-enable flag is set. It produces a locked pair of acknowledge bus requests on a simple request/done handshake. The byte returned by the second acknowledge is presented as the interrupt vector with a one-clock valid strobe, provided the request stayed asserted for the whole sequence.

Top module: `irq_ack_seq`

## Requirements
- R1: Each of `rst_req_a`, `mreq_a` and `nmi_a` passes through two flops. A change driven before a clock edge affects the outputs no earlier than the third clock edge. For example, with `ie` set and the block idle, raising `mreq_a` gives `bus_req` = 0 after two edges and 1 after the third.
- R2: `warm_rst` rises at the edge on which the synchronised reset request has been sampled high for 15 consecutive clocks. It stays high while the request stays high and falls at the first edge that samples it low. A shorter pulse leaves `warm_rst` at 0.
- R3: A synchronised rising edge of the non-maskable input is accepted only if the line was sampled low on at least 4 consecutive clocks just before it. An accepted edge makes `nmi_evt` high for exactly one clock, once the sequencer is idle.
- R4: The non-maskable path ignores `ie`. When an accepted edge is pending and the sequencer is idle, `nmi_evt` is issued before any new acknowledge sequence starts. `nmi_evt` is never high while `bus_lock` is high.
- R5: When idle, with nothing pending, `ie` = 1 and the synchronised maskable request high, the next edge raises `bus_req` and `bus_lock`. With `ie` = 0 the maskable request has no effect.
- R6: `bus_req` stays high until a clock in which `bus_done` is sampled high. `bus_done` has no effect while `bus_req` is low.
- R7: `bus_lock` is high from the first acknowledge request until the second is done. Between the two requests there is exactly one clock with `bus_lock` = 1 and `bus_req` = 0.
- R8: On the clock in which the second acknowledge is done, `bus_rdata` is captured. `vec_data` shows it from the next clock on, and `vec_valid` is high for that one clock.
- R9: If the synchronised maskable request is low on any clock from the start of the first acknowledge to the completion of the second, both bus requests still complete but `vec_valid` stays 0.
- R10: While `rst_n` is low, and on the clock after `warm_rst` is seen high, `bus_req`, `bus_lock`, `nmi_evt` and `vec_valid` are 0. A warm reset also discards any pending non-maskable event and any acknowledge sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the block's flops |
| rst_req_a | input | 1 | Asynchronous warm reset request, active high |
| mreq_a | input | 1 | Asynchronous maskable interrupt request, level, active high |
| nmi_a | input | 1 | Asynchronous non-maskable interrupt request, rising-edge |
| ie | input | 1 | Interrupt-enable flag from the core, synchronous |
| bus_done | input | 1 | Bus engine reports the current acknowledge finished |
| bus_rdata | input | VEC_W | Data returned by the bus engine with `bus_done` |
| bus_req | output | 1 | Acknowledge bus cycle request |
| bus_lock | output | 1 | Bus lock spanning the acknowledge pair |
| nmi_evt | output | 1 | One-clock non-maskable event to the core |
| vec_valid | output | 1 | One-clock strobe qualifying `vec_data` |
| vec_data | output | VEC_W | Vector byte from the second acknowledge |
| warm_rst | output | 1 | Qualified warm reset to the core |

## Verification
Every output comes from a register or a state decode, so a wrong internal state shows at the ports on the next clock edge. If the sequencer state goes wrong, `bus_req` or `bus_lock` deviate, or the gap clock between the two acknowledges is missing. If the abandonment flag goes wrong, `vec_valid` appears or disappears on the clock after the second `bus_done`. A wrong low-time or reset-length counter shows only when the input later rises or falls: an `nmi_evt` or `warm_rst` edge arrives one or more clocks off, or not at all. The bench therefore drives input pulses just below and just above both thresholds, and lines up non-maskable edges and warm resets with acknowledge sequences in flight.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_ACK1 = 2'd1,
        SQ_GAP  = 2'd2,
        SQ_ACK2 = 2'd3
    } sq_state_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_a,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] st_d [STAGES];
    logic [WIDTH-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = d_a;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q[g] <= '0;
                else        st_q[g] <= st_d[g];
            end
        end
    endgenerate

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/rst_len_filter.sv
module rst_len_filter #(
    parameter int MIN_LEN = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    output logic warm_o
);
    localparam int CW = $clog2(MIN_LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          warm;
    } flt_t;

    flt_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (req_s) begin
            if (f_q.cnt < CW'(MIN_LEN)) f_d.cnt = f_q.cnt + CW'(1);
            f_d.warm = (f_q.cnt >= CW'(MIN_LEN - 1));
        end else begin
            f_d.cnt  = '0;
            f_d.warm = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign warm_o = f_q.warm;

    AST_WARM_AFTER_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.warm |-> (f_q.cnt == CW'(MIN_LEN))) else $error("warm reset before full count"); // R2
    AST_WARM_DROPS_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !req_s |=> !f_q.warm) else $error("warm reset held after request low"); // R2
endmodule

// File: rtl/nmi_edge_qual.sv
module nmi_edge_qual #(
    parameter int MIN_LOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_s,
    output logic edge_o
);
    localparam int LW = $clog2(MIN_LOW + 1);

    typedef struct packed {
        logic [LW-1:0] low;
        logic          prev;
    } nq_t;

    nq_t n_d, n_q;

    always_comb begin
        n_d      = n_q;
        n_d.prev = nmi_s;
        if (nmi_s)                      n_d.low = '0;
        else if (n_q.low < LW'(MIN_LOW)) n_d.low = n_q.low + LW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) n_q <= '0;
        else        n_q <= n_d;
    end

    assign edge_o = nmi_s && !n_q.prev && (n_q.low >= LW'(MIN_LOW));

    AST_NMI_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o) else $error("edge held two clocks"); // R3
endmodule

// File: rtl/ack_seq.sv
module ack_seq
    import irq_seq_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm,
    input  logic             nmi_edge,
    input  logic             mreq_s,
    input  logic             ie,
    input  logic             bus_done,
    input  logic [VEC_W-1:0] bus_rdata,
    output logic             bus_req,
    output logic             bus_lock,
    output logic             nmi_evt,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_data
);
    typedef struct packed {
        sq_state_e        st;
        logic             pend;
        logic             ok;
        logic             evt;
        logic             vv;
        logic [VEC_W-1:0] vec;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.evt  = 1'b0;
        s_d.vv   = 1'b0;
        s_d.pend = s_q.pend | nmi_edge;
        unique case (s_q.st)
            SQ_IDLE: begin
                if (s_q.pend) begin
                    s_d.evt  = 1'b1;
                    s_d.pend = nmi_edge;
                end else if (mreq_s && ie) begin
                    s_d.st = SQ_ACK1;
                    s_d.ok = 1'b1;
                end
            end
            SQ_ACK1: begin
                s_d.ok = s_q.ok & mreq_s;
                if (bus_done) s_d.st = SQ_GAP;
            end
            SQ_GAP: begin
                s_d.ok = s_q.ok & mreq_s;
                s_d.st = SQ_ACK2;
            end
            SQ_ACK2: begin
                s_d.ok = s_q.ok & mreq_s;
                if (bus_done) begin
                    s_d.vec = bus_rdata;
                    s_d.vv  = s_q.ok & mreq_s;
                    s_d.st  = SQ_IDLE;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
        if (warm) begin
            s_d.st   = SQ_IDLE;
            s_d.pend = 1'b0;
            s_d.ok   = 1'b0;
            s_d.evt  = 1'b0;
            s_d.vv   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, pend: 1'b0, ok: 1'b0, evt: 1'b0, vv: 1'b0, vec: '0};
        else        s_q <= s_d;
    end

    assign bus_req   = (s_q.st == SQ_ACK1) || (s_q.st == SQ_ACK2);
    assign bus_lock  = (s_q.st != SQ_IDLE);
    assign nmi_evt   = s_q.evt;
    assign vec_valid = s_q.vv;
    assign vec_data  = s_q.vec;

    AST_REQ_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_lock) else $error("request without lock"); // R7
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n || warm)
        (bus_req && !bus_done) |=> bus_req) else $error("request dropped early"); // R6
    AST_GAP_CLOCK: assert property (@(posedge clk) disable iff (!rst_n || warm)
        (s_q.st == SQ_ACK1 && bus_done) |=> (bus_lock && !bus_req)) else $error("no gap clock"); // R7
    AST_VV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid) else $error("vector strobe too long"); // R8
    AST_NMI_NOT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_evt |-> !bus_lock) else $error("nmi event inside locked pair"); // R4
    AST_WARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        warm |=> (!bus_req && !bus_lock && !nmi_evt && !vec_valid)) else $error("warm reset did not clear"); // R10
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
    parameter int SYNC_STAGES  = 2,
    parameter int MIN_RST_CLKS = 15,
    parameter int NMI_LOW_CLKS = 4,
    parameter int VEC_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_req_a,
    input  logic             mreq_a,
    input  logic             nmi_a,
    input  logic             ie,
    input  logic             bus_done,
    input  logic [VEC_W-1:0] bus_rdata,
    output logic             bus_req,
    output logic             bus_lock,
    output logic             nmi_evt,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vec_data,
    output logic             warm_rst
);
    localparam int N_ASYNC = 3;

    logic [N_ASYNC-1:0] raw_a;
    logic [N_ASYNC-1:0] syn;
    logic               nmi_edge;

    assign raw_a = {nmi_a, mreq_a, rst_req_a};

    irq_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_a   (raw_a),
        .q     (syn)
    );

    rst_len_filter #(.MIN_LEN(MIN_RST_CLKS)) u_rstf (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_s  (syn[0]),
        .warm_o (warm_rst)
    );

    nmi_edge_qual #(.MIN_LOW(NMI_LOW_CLKS)) u_nmiq (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi_s  (syn[2]),
        .edge_o (nmi_edge)
    );

    ack_seq #(.VEC_W(VEC_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .warm      (warm_rst),
        .nmi_edge  (nmi_edge),
        .mreq_s    (syn[1]),
        .ie        (ie),
        .bus_done  (bus_done),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_lock  (bus_lock),
        .nmi_evt   (nmi_evt),
        .vec_valid (vec_valid),
        .vec_data  (vec_data)
    );

    AST_LOCK_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warm_rst) |=> !bus_lock) else $error("lock kept across warm reset"); // R10
endmodule

// File: tb/tb_irq_ack_seq.sv
module tb_irq_ack_seq;
    localparam int CLK_PERIOD = 10;
    localparam int RST_MIN    = 15;
    localparam int LOW_MIN    = 4;
    localparam int WD_LIMIT   = 40000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       rst_req_a = 1'b0, mreq_a = 1'b0, nmi_a = 1'b0, ie = 1'b0;
    logic       bus_done = 1'b0;
    logic [7:0] bus_rdata = 8'h00;
    logic       bus_req, bus_lock, nmi_evt, vec_valid, warm_rst;
    logic [7:0] vec_data;

    int vectors = 0;
    int fails   = 0;
    bit resp_en = 1'b1;
    bit finished = 1'b0;

    irq_ack_seq dut (
        .clk(clk), .rst_n(rst_n), .rst_req_a(rst_req_a), .mreq_a(mreq_a),
        .nmi_a(nmi_a), .ie(ie), .bus_done(bus_done), .bus_rdata(bus_rdata),
        .bus_req(bus_req), .bus_lock(bus_lock), .nmi_evt(nmi_evt),
        .vec_valid(vec_valid), .vec_data(vec_data), .warm_rst(warm_rst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: pipelines of samples, counters, a phase number.
    bit r1, r2, m1, m2, n1, n2, nprev;
    int low_run, rst_run, phase;   // phase: 0 idle, 1 first ack, 2 gap, 3 second ack
    bit m_warm, pend, intact, m_evt, m_vv;
    logic [7:0] m_vec;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r1 = 0; r2 = 0; m1 = 0; m2 = 0; n1 = 0; n2 = 0; nprev = 0;
            low_run = 0; rst_run = 0; phase = 0;
            m_warm = 0; pend = 0; intact = 0; m_evt = 0; m_vv = 0; m_vec = 8'h00;
        end else begin
            bit accepted, nx_warm, nx_pend, nx_intact, nx_evt, nx_vv;
            int nx_phase;
            logic [7:0] nx_vec;
            accepted  = n2 && !nprev && (low_run >= LOW_MIN);
            nx_warm   = r2 && (rst_run + 1 >= RST_MIN);
            nx_pend   = pend || accepted;
            nx_intact = intact;
            nx_evt    = 0;
            nx_vv     = 0;
            nx_phase  = phase;
            nx_vec    = m_vec;
            if (phase == 0) begin
                if (pend) begin nx_evt = 1; nx_pend = accepted; end
                else if (m2 && ie) begin nx_phase = 1; nx_intact = 1; end
            end else begin
                nx_intact = intact && m2;
                if (phase == 1 && bus_done) nx_phase = 2;
                else if (phase == 2) nx_phase = 3;
                else if (phase == 3 && bus_done) begin
                    nx_phase = 0; nx_vec = bus_rdata; nx_vv = intact && m2;
                end
            end
            if (m_warm) begin
                nx_phase = 0; nx_pend = 0; nx_intact = 0; nx_evt = 0; nx_vv = 0;
            end
            rst_run = r2 ? ((rst_run < RST_MIN) ? rst_run + 1 : RST_MIN) : 0;
            low_run = n2 ? 0 : ((low_run < LOW_MIN) ? low_run + 1 : LOW_MIN);
            nprev = n2;
            m_warm = nx_warm; pend = nx_pend; intact = nx_intact;
            m_evt = nx_evt; m_vv = nx_vv; phase = nx_phase; m_vec = nx_vec;
            r2 = r1; r1 = rst_req_a;
            m2 = m1; m1 = mreq_a;
            n2 = n1; n1 = nmi_a;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Per-clock comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (!finished) begin
            chk("R2 warm_rst", {7'b0, warm_rst}, {7'b0, m_warm});
            chk("R5 R6 bus_req", {7'b0, bus_req}, {7'b0, (phase == 1 || phase == 3)});
            chk("R7 bus_lock", {7'b0, bus_lock}, {7'b0, (phase != 0)});
            chk("R3 R4 nmi_evt", {7'b0, nmi_evt}, {7'b0, m_evt});
            chk("R8 R9 vec_valid", {7'b0, vec_valid}, {7'b0, m_vv});
            if (m_vv) chk("R8 vec_data", vec_data, m_vec);
        end
    end

    // Bus engine stand-in: random completion latency, stray done pulses when idle.
    always @(negedge clk) begin
        bus_rdata <= 8'($urandom);
        if (!resp_en)     bus_done <= 1'b0;
        else if (bus_req) bus_done <= ($urandom % 3) == 0;
        else              bus_done <= ($urandom % 5) == 0;   // R6: ignored while idle
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_vec(input int limit);
        for (int i = 0; i < limit && !vec_valid; i++) @(negedge clk);
    endtask

    task automatic summary;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #1 rst_n = 1'b0;
        tick(3);
        chk("R10 reset bus_lock", {7'b0, bus_lock}, 8'h00);
        chk("R10 reset nmi_evt", {7'b0, nmi_evt}, 8'h00);
        rst_n = 1'b1;
        tick(6);

        // R1: two synchroniser flops, then one sequencer register
        resp_en = 1'b0;
        ie = 1'b1; mreq_a = 1'b1;
        tick(2);
        chk("R1 bus_req after two edges", {7'b0, bus_req}, 8'h00);
        tick(1);
        chk("R1 bus_req after three edges", {7'b0, bus_req}, 8'h01);
        resp_en = 1'b1;
        wait_vec(200);
        chk("R8 vector delivered", {7'b0, vec_valid}, 8'h01);
        tick(1);
        mreq_a = 1'b0;
        tick(12);

        // R5: enable clear, request ignored
        ie = 1'b0; mreq_a = 1'b1;
        tick(20);
        chk("R5 no request with ie clear", {7'b0, bus_lock}, 8'h00);
        mreq_a = 1'b0; ie = 1'b1;
        tick(6);

        // R9: request dropped mid sequence
        resp_en = 1'b0;
        mreq_a = 1'b1;
        tick(5);
        mreq_a = 1'b0;
        resp_en = 1'b1;
        tick(40);

        // R3: low times 2, 3 (rejected), 4, 6 (accepted)
        nmi_a = 1'b1; tick(6);
        nmi_a = 1'b0; tick(2); nmi_a = 1'b1; tick(6);
        nmi_a = 1'b0; tick(3); nmi_a = 1'b1; tick(6);
        nmi_a = 1'b0; tick(4); nmi_a = 1'b1; tick(6);
        nmi_a = 1'b0; tick(6); nmi_a = 1'b1; tick(6);
        nmi_a = 1'b0; tick(8);

        // R4: edge during an acknowledge pair, enable cleared
        resp_en = 1'b0;
        mreq_a = 1'b1;
        tick(4);
        ie = 1'b0;
        nmi_a = 1'b1;
        tick(6);
        resp_en = 1'b1;
        wait_vec(200);
        tick(1);
        mreq_a = 1'b0; nmi_a = 1'b0; ie = 1'b1;
        tick(10);

        // R2: pulses of 10 and 14 clocks rejected, 15 accepted
        rst_req_a = 1'b1; tick(10); rst_req_a = 1'b0; tick(6);
        chk("R2 short pulse ignored", {7'b0, warm_rst}, 8'h00);
        rst_req_a = 1'b1; tick(14); rst_req_a = 1'b0; tick(6);
        chk("R2 14-clock pulse ignored", {7'b0, warm_rst}, 8'h00);
        rst_req_a = 1'b1; tick(15); rst_req_a = 1'b0; tick(6);

        // R10: warm reset during a locked pair, with a pending edge
        resp_en = 1'b0;
        mreq_a = 1'b1;
        tick(5);
        nmi_a = 1'b1;
        rst_req_a = 1'b1;
        tick(20);
        chk("R10 lock cleared by warm reset", {7'b0, bus_lock}, 8'h00);
        chk("R10 request cleared by warm reset", {7'b0, bus_req}, 8'h00);
        mreq_a = 1'b0;
        rst_req_a = 1'b0;
        resp_en = 1'b1;
        tick(10);
        nmi_a = 1'b0;
        tick(10);

        // Mixed random traffic
        begin
            int rst_left = 0;
            for (int c = 0; c < 5000; c++) begin
                if ($urandom % 40 == 0) mreq_a = ~mreq_a;
                if ($urandom % 70 == 0) ie = ~ie;
                if ($urandom % 6 == 0)  nmi_a = ~nmi_a;
                if (rst_left > 0) begin
                    rst_left--;
                    if (rst_left == 0) rst_req_a = 1'b0;
                end else if ($urandom % 300 == 0) begin
                    rst_req_a = 1'b1;
                    rst_left = 8 + int'($urandom % 16);
                end
                tick(1);
            end
        end
        summary();
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired at %0t: got running expected finished", $time);
            summary();
        end
    end
endmodule